// File: doc/BRIEF.md
# Paged Network Controller Register Front End

This block is the host-side register window of a simple Ethernet controller. A host reaches it through a 4-bit offset and an 8-bit data bus. Offset 0 always holds the command register. Offsets 1 to 15 are decoded together with a 2-bit page field that lives in the command register, so the same sixteen slots reach two different register sets. Page 0 holds the ring, transmit, remote-transfer and configuration settings. Page 1 holds the station address, the current receive page and the multicast hash mask. Reads are combinational from the offset, and writes take effect at the clock edge.

The block keeps the interrupt status and mask and drives one level-sensitive interrupt line. Neighbouring engines report events by pulsing event inputs, and the host acknowledges an event by writing a one to its status bit. A command write can also raise one-cycle strobes for the neighbours. One strobe starts a transmission. The other announces that the remote-transfer pointer and count have been preloaded for a send-packet sequence. Every stored setting is also driven out in parallel to the engines that use it.

Top module: `nic_regbank`

## Requirements
- R1: After reset the command register reads 0x21, the interrupt status reads 0x80, the interrupt mask and all other stored registers are zero, and irq and both strobes are low.
- R2: Offset 0 reads and writes the command register on every page. For offsets 1 to 15 the page comes from command bits 7:6. On page 1, offsets 1 to 6 are station address bytes 0 to 5, offset 7 is the current page, and offsets 8 to 15 are multicast mask bytes 0 to 7. Pages 2 and 3 ignore writes and read 0x00.
- R3: Command layout: bit 0 stop, bit 1 start, bit 2 transmit, bits 5:3 remote-transfer code, bits 7:6 page. A command write whose bits 5:3 are 000 stores 100 in that field.
- R4: A command write with bit 0 set sets status bit 7. A command write that sets bit 1 while the stored bit 1 is clear clears status bit 7, and this clear wins over a set in the same write.
- R5: Writing page 0 offset 7 clears each status bit 6:0 whose data bit is 1; status bit 7 is never changed by this write. A high bit of evt_set[6:0] sets the matching status bit, and wins over a clear in the same cycle.
- R6: irq is high exactly when status AND mask is nonzero, reflecting the registers updated at the previous edge. The mask is written at page 0 offset 15.
- R7: A command write with bit 2 set while the transmit count is nonzero raises tx_go for the next cycle, sets status bit 1, makes page 0 offset 4 read 0x01, and leaves stored command bit 2 at 1. With a zero count none of this happens and stored bit 2 is 0.
- R8: A command write whose stored transfer code is 3 loads rdma_start with boundary×256 and rdma_count with 2, and raises sendpkt_go for the next cycle.
- R9: Page 0 offsets 10 and 11 read 0xFF until some command write has set bit 1, and read 0x50 and 0x43 from then on.
- R10: Page 0 offsets 3, 4, 7, 8 and 9 read boundary, transmit status, interrupt status, and the low and high bytes of rdma_start. Offsets 1, 2, 5, 6 and 12 to 15 read 0x00.
- R11: Page 0 writes go to these registers. Offset 1 is ring_start and offset 2 is ring_stop. Offset 3 is boundary and offset 4 is tx_page. Offsets 5 and 6 are the low and high bytes of tx_count. Offsets 8 and 9 are the low and high bytes of rdma_start, and offsets 10 and 11 those of rdma_count. Offset 12 is rx_cfg, 13 is tx_cfg and 14 is data_cfg. Each register appears on its own output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| evt_set | input | 7 | Event pulses that set status bits 6:0 |
| irq | output | 1 | Level interrupt request |
| tx_go | output | 1 | One-cycle transmit start strobe |
| sendpkt_go | output | 1 | One-cycle send-packet preload strobe |
| ring_start | output | 8 | First page of the receive ring |
| ring_stop | output | 8 | Page past the end of the receive ring |
| boundary | output | 8 | Ring boundary page |
| tx_page | output | 8 | First page of the frame to send |
| tx_count | output | 16 | Byte count of the frame to send |
| rdma_start | output | 16 | Remote transfer start address |
| rdma_count | output | 16 | Remote transfer byte count |
| rx_cfg | output | 8 | Receive configuration |
| tx_cfg | output | 8 | Transmit configuration |
| data_cfg | output | 8 | Data path configuration |
| cur_page | output | 8 | Current receive page |
| station_addr | output | 48 | Station address, byte 0 in bits 7:0 |
| mcast_mask | output | 64 | Multicast mask, byte 0 in bits 7:0 |

## Verification
The assertions rely on the single write port: only one offset can be written in a cycle, so a command write and a status-clear write never fall on the same edge. They also rely on the transmit count and boundary never changing on the edge where a command write lands. The status checks further assume that only bits 6:0 have event lines, and that status bit 7 moves only through command writes. The stimulus drives one write per cycle through the real port, lets events collide with clears on purpose, and ends with a random phase over every page, offset and event pattern. A behavioural model in the bench is compared with every output on every cycle.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

   localparam int BYTE_W    = 8;
   localparam int OFF_W     = 4;
   localparam int PAGE_W    = 2;
   localparam int STAT_W    = 8;
   localparam int EVT_W     = STAT_W - 1;
   localparam int STA_BYTES = 6;
   localparam int MC_BYTES  = 8;
   localparam int CNT_W     = 2 * BYTE_W;

   // command register bit positions (decoded by neighbours)
   localparam int CB_STOP   = 0;
   localparam int CB_START  = 1;
   localparam int CB_TX     = 2;
   localparam int CB_DMA_LO = 3;
   localparam int CB_DMA_HI = 5;
   localparam int CB_PG_LO  = 6;
   localparam int CB_PG_HI  = 7;

   // interrupt status positions used by this block
   localparam int SB_TX_OK  = 1;
   localparam int SB_RESET  = 7;

   // page 1 layout bases
   localparam logic [OFF_W-1:0] P1_STA_BASE = 4'd1;
   localparam logic [OFF_W-1:0] P1_CUR      = 4'd7;
   localparam logic [OFF_W-1:0] P1_MC_BASE  = 4'd8;

   typedef enum logic [2:0] {
      XFER_NONE  = 3'd0,
      XFER_READ  = 3'd1,
      XFER_WRITE = 3'd2,
      XFER_SEND  = 3'd3,
      XFER_ABORT = 3'd4
   } xfer_code_e;

   typedef enum logic [OFF_W-1:0] {
      P0_CMD    = 4'h0,
      P0_RSTART = 4'h1,
      P0_RSTOP  = 4'h2,
      P0_BOUND  = 4'h3,
      P0_TXPG   = 4'h4,
      P0_TCLO   = 4'h5,
      P0_TCHI   = 4'h6,
      P0_STAT   = 4'h7,
      P0_RALO   = 4'h8,
      P0_RAHI   = 4'h9,
      P0_RCLO   = 4'hA,
      P0_RCHI   = 4'hB,
      P0_RXC    = 4'hC,
      P0_TXC    = 4'hD,
      P0_DC     = 4'hE,
      P0_MASK   = 4'hF
   } p0_off_e;

   function automatic logic [2:0] fix_xfer(input logic [2:0] f);
      return (f == XFER_NONE) ? XFER_ABORT : f;
   endfunction

endpackage

// File: rtl/nic_byte_bank.sv
module nic_byte_bank
   import nic_regs_pkg::*;
#(
   parameter int NBYTES = 6,
   parameter int BASE   = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [OFF_W-1:0]               off,
   input  logic [BYTE_W-1:0]              d,
   output logic [NBYTES-1:0][BYTE_W-1:0]  q
);

   localparam int LAST = BASE + NBYTES - 1;

   if (NBYTES < 1 || BASE < 1 || LAST > (1 << OFF_W) - 1) begin : g_bad_range
      $error("nic_byte_bank: bank does not fit in offsets 1..15");
   end

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 r <= '0;
         else if (we && off == OFF_W'(BASE + i))     r <= d;
      end
      assign q[i] = r;
   end

endmodule

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
   import nic_regs_pkg::*;
#(
   parameter logic [BYTE_W-1:0] CMD_RESET = 8'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [BYTE_W-1:0] d,
   input  logic              tx_count_nz,
   output logic [BYTE_W-1:0] cmd_q,
   output logic              started_q,
   output logic              tx_accept,
   output logic              send_load,
   output logic              rflag_set,
   output logic              rflag_clr,
   output logic              tx_go_q,
   output logic              send_go_q
);

   if (CMD_RESET[CB_DMA_HI:CB_DMA_LO] == 3'b000) begin : g_bad_reset
      $error("nic_cmd_ctl: reset command must carry a nonzero transfer code");
   end

   logic [2:0] xfer_fix;

   always_comb begin
      xfer_fix  = fix_xfer(d[CB_DMA_HI:CB_DMA_LO]);
      tx_accept = cmd_we && d[CB_TX] && tx_count_nz;
      send_load = cmd_we && (xfer_fix == XFER_SEND);
      rflag_set = cmd_we && d[CB_STOP];
      rflag_clr = cmd_we && d[CB_START] && !cmd_q[CB_START];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= CMD_RESET;
         started_q <= 1'b0;
         tx_go_q   <= 1'b0;
         send_go_q <= 1'b0;
      end else begin
         tx_go_q   <= tx_accept;
         send_go_q <= send_load;
         if (cmd_we) begin
            cmd_q <= {d[CB_PG_HI:CB_PG_LO], xfer_fix, tx_accept,
                      d[CB_START], d[CB_STOP]};
            if (d[CB_START]) started_q <= 1'b1;
         end
      end
   end

   assert_xfer_nonzero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> (cmd_q[CB_DMA_HI:CB_DMA_LO] != 3'b000));

   assert_started_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      started_q |=> started_q);

   assert_tx_bit_follows_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_we |=> (cmd_q[CB_TX] == tx_go_q));

endmodule

// File: rtl/nic_int_ctl.sv
module nic_int_ctl
   import nic_regs_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_we,
   input  logic [EVT_W-1:0]  clr_d,
   input  logic              mask_we,
   input  logic [STAT_W-1:0] mask_d,
   input  logic [EVT_W-1:0]  evt,
   input  logic              tx_ok,
   input  logic              rflag_set,
   input  logic              rflag_clr,
   output logic [STAT_W-1:0] status_q,
   output logic [STAT_W-1:0] mask_q,
   output logic              irq_o
);

   localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << SB_RESET;

   logic [STAT_W-1:0] status_d;
   logic              pending;

   always_comb begin
      status_d = status_q;
      if (clr_we) status_d[EVT_W-1:0] = status_d[EVT_W-1:0] & ~clr_d;
      status_d[EVT_W-1:0] = status_d[EVT_W-1:0] | evt;
      if (tx_ok) status_d[SB_TX_OK] = 1'b1;
      if (rflag_clr)      status_d[SB_RESET] = 1'b0;
      else if (rflag_set) status_d[SB_RESET] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= STAT_RST;
         mask_q   <= '0;
      end else begin
         status_q <= status_d;
         if (mask_we) mask_q <= mask_d;
      end
   end

   assign pending = |(status_q & mask_q);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pending;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = pending;
      assert_mask_zero_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (mask_we && mask_d == '0) |=> !irq_o);
   end

   assert_w1c_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && ((evt & clr_d) == '0) && !tx_ok)
      |=> ((status_q[EVT_W-1:0] & $past(clr_d)) == '0));

   assert_evt_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((status_q[EVT_W-1:0] & $past(evt)) == $past(evt)));

   assert_reset_bit_held_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && status_q[SB_RESET]) |=> status_q[SB_RESET]);

   assert_reset_bit_set_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rflag_set && !rflag_clr) |=> status_q[SB_RESET]);

   assert_reset_bit_clr_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      rflag_clr |=> !status_q[SB_RESET]);

endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
   import nic_regs_pkg::*;
#(
   parameter logic [7:0] ID_HI     = 8'h50,
   parameter logic [7:0] ID_LO     = 8'h43,
   parameter logic [7:0] CMD_RESET = 8'h21,
   parameter bit         IRQ_REG   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [3:0]   addr,
   input  logic [7:0]   wdata,
   output logic [7:0]   rdata,
   input  logic [6:0]   evt_set,
   output logic         irq,
   output logic         tx_go,
   output logic         sendpkt_go,
   output logic [7:0]   ring_start,
   output logic [7:0]   ring_stop,
   output logic [7:0]   boundary,
   output logic [7:0]   tx_page,
   output logic [15:0]  tx_count,
   output logic [15:0]  rdma_start,
   output logic [15:0]  rdma_count,
   output logic [7:0]   rx_cfg,
   output logic [7:0]   tx_cfg,
   output logic [7:0]   data_cfg,
   output logic [7:0]   cur_page,
   output logic [47:0]  station_addr,
   output logic [63:0]  mcast_mask
);

   localparam logic [BYTE_W-1:0] ID_BLANK = '1;
   localparam logic [BYTE_W-1:0] TX_DONE  = 8'h01;
   localparam logic [CNT_W-1:0]  SEND_CNT = CNT_W'(2);

   if (BYTE_W != 8 || OFF_W != 4) begin : g_bad_geometry
      $error("nic_regbank: register window must be 16 x 8 bits");
   end

   // ---------------- decode ----------------
   logic [BYTE_W-1:0] cmd_q;
   logic [PAGE_W-1:0] page;
   logic              cmd_we, pg0_we, pg1_we;

   assign page   = cmd_q[CB_PG_HI:CB_PG_LO];
   assign cmd_we = wr_en && (addr == P0_CMD);
   assign pg0_we = wr_en && (addr != P0_CMD) && (page == 2'd0);
   assign pg1_we = wr_en && (addr != P0_CMD) && (page == 2'd1);

   // ---------------- command ----------------
   logic started_q, tx_accept, send_load, rflag_set, rflag_clr;
   logic [CNT_W-1:0] tcnt_q;

   nic_cmd_ctl #(.CMD_RESET(CMD_RESET)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_we),
      .d           (wdata),
      .tx_count_nz (|tcnt_q),
      .cmd_q       (cmd_q),
      .started_q   (started_q),
      .tx_accept   (tx_accept),
      .send_load   (send_load),
      .rflag_set   (rflag_set),
      .rflag_clr   (rflag_clr),
      .tx_go_q     (tx_go),
      .send_go_q   (sendpkt_go)
   );

   // ---------------- interrupt ----------------
   logic [STAT_W-1:0] status_q, mask_q;

   nic_int_ctl #(.IRQ_REG(IRQ_REG)) u_int (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_we    (pg0_we && addr == P0_STAT),
      .clr_d     (wdata[EVT_W-1:0]),
      .mask_we   (pg0_we && addr == P0_MASK),
      .mask_d    (wdata),
      .evt       (evt_set),
      .tx_ok     (tx_accept),
      .rflag_set (rflag_set),
      .rflag_clr (rflag_clr),
      .status_q  (status_q),
      .mask_q    (mask_q),
      .irq_o     (irq)
   );

   // ---------------- page 0 storage ----------------
   logic [BYTE_W-1:0] rstart_q, rstop_q, bnd_q, txpg_q, rxc_q, txc_q, dc_q, tsr_q;
   logic [CNT_W-1:0]  ra_q, rc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rstart_q <= '0; rstop_q <= '0; bnd_q <= '0; txpg_q <= '0;
         tcnt_q   <= '0; ra_q    <= '0; rc_q  <= '0;
         rxc_q    <= '0; txc_q   <= '0; dc_q  <= '0; tsr_q <= '0;
      end else begin
         if (tx_accept) tsr_q <= TX_DONE;
         if (send_load) begin
            ra_q <= {bnd_q, {BYTE_W{1'b0}}};
            rc_q <= SEND_CNT;
         end
         if (pg0_we) begin
            unique case (p0_off_e'(addr))
               P0_RSTART: rstart_q <= wdata;
               P0_RSTOP:  rstop_q  <= wdata;
               P0_BOUND:  bnd_q    <= wdata;
               P0_TXPG:   txpg_q   <= wdata;
               P0_TCLO:   tcnt_q[BYTE_W-1:0]       <= wdata;
               P0_TCHI:   tcnt_q[CNT_W-1:BYTE_W]   <= wdata;
               P0_RALO:   ra_q[BYTE_W-1:0]         <= wdata;
               P0_RAHI:   ra_q[CNT_W-1:BYTE_W]     <= wdata;
               P0_RCLO:   rc_q[BYTE_W-1:0]         <= wdata;
               P0_RCHI:   rc_q[CNT_W-1:BYTE_W]     <= wdata;
               P0_RXC:    rxc_q    <= wdata;
               P0_TXC:    txc_q    <= wdata;
               P0_DC:     dc_q     <= wdata;
               default:   ;
            endcase
         end
      end
   end

   // ---------------- page 1 storage ----------------
   logic [STA_BYTES-1:0][BYTE_W-1:0] sta_q;
   logic [MC_BYTES-1:0][BYTE_W-1:0]  mc_q;
   logic [BYTE_W-1:0]                cur_q;

   nic_byte_bank #(.NBYTES(STA_BYTES), .BASE(int'(P1_STA_BASE))) u_sta (
      .clk (clk), .rst_n (rst_n), .we (pg1_we), .off (addr), .d (wdata), .q (sta_q)
   );

   nic_byte_bank #(.NBYTES(MC_BYTES), .BASE(int'(P1_MC_BASE))) u_mc (
      .clk (clk), .rst_n (rst_n), .we (pg1_we), .off (addr), .d (wdata), .q (mc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cur_q <= '0;
      else if (pg1_we && addr == P1_CUR)  cur_q <= wdata;
   end

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      if (addr == P0_CMD) begin
         rdata = cmd_q;
      end else if (page == 2'd0) begin
         unique case (p0_off_e'(addr))
            P0_BOUND: rdata = bnd_q;
            P0_TXPG:  rdata = tsr_q;
            P0_STAT:  rdata = status_q;
            P0_RALO:  rdata = ra_q[BYTE_W-1:0];
            P0_RAHI:  rdata = ra_q[CNT_W-1:BYTE_W];
            P0_RCLO:  rdata = started_q ? ID_HI : ID_BLANK;
            P0_RCHI:  rdata = started_q ? ID_LO : ID_BLANK;
            default:  rdata = '0;
         endcase
      end else if (page == 2'd1) begin
         if (addr == P1_CUR) rdata = cur_q;
         for (int i = 0; i < STA_BYTES; i++)
            if (addr == OFF_W'(int'(P1_STA_BASE) + i)) rdata = sta_q[i];
         for (int i = 0; i < MC_BYTES; i++)
            if (addr == OFF_W'(int'(P1_MC_BASE) + i)) rdata = mc_q[i];
      end
   end

   // ---------------- outputs ----------------
   assign ring_start   = rstart_q;
   assign ring_stop    = rstop_q;
   assign boundary     = bnd_q;
   assign tx_page      = txpg_q;
   assign tx_count     = tcnt_q;
   assign rdma_start   = ra_q;
   assign rdma_count   = rc_q;
   assign rx_cfg       = rxc_q;
   assign tx_cfg       = txc_q;
   assign data_cfg     = dc_q;
   assign cur_page     = cur_q;
   assign station_addr = sta_q;
   assign mcast_mask   = mc_q;

   // ---------------- assertions ----------------
   assert_tx_needs_count_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> (tcnt_q != '0));

   assert_tx_sets_status_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> (status_q[SB_TX_OK] && tsr_q == TX_DONE));

   assert_send_preload_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      sendpkt_go |-> (rc_q == SEND_CNT && ra_q == {bnd_q, {BYTE_W{1'b0}}}));

   assert_high_page_inert_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != P0_CMD && page[1]) |=> ($stable(sta_q) && $stable(mc_q) && $stable(cur_q)));

endmodule

// File: tb/nic_regbank_test.sv
module nic_regbank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [6:0]  evt_set = '0;
   logic [7:0]  rdata;
   logic        irq, tx_go, sendpkt_go;
   logic [7:0]  ring_start, ring_stop, boundary, tx_page, rx_cfg, tx_cfg, data_cfg, cur_page;
   logic [15:0] tx_count, rdma_start, rdma_count;
   logic [47:0] station_addr;
   logic [63:0] mcast_mask;

   int n_checks = 0;
   int n_fail   = 0;
   bit live     = 1'b0;

   always #2 clk = ~clk;

   nic_regbank uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt_set(evt_set), .irq(irq), .tx_go(tx_go),
      .sendpkt_go(sendpkt_go), .ring_start(ring_start), .ring_stop(ring_stop),
      .boundary(boundary), .tx_page(tx_page), .tx_count(tx_count),
      .rdma_start(rdma_start), .rdma_count(rdma_count), .rx_cfg(rx_cfg),
      .tx_cfg(tx_cfg), .data_cfg(data_cfg), .cur_page(cur_page),
      .station_addr(station_addr), .mcast_mask(mcast_mask)
   );

   // ---------------- reference model ----------------
   logic [7:0]  m_cmd, m_isr, m_imr, m_tsr, m_rs, m_rp, m_bnd, m_tpg, m_rx, m_tx, m_dc, m_cur;
   logic [15:0] m_tc, m_ra, m_rc;
   logic [7:0]  m_sta [6];
   logic [7:0]  m_mc  [8];
   bit          m_started, m_txgo, m_spgo;

   task automatic model_reset();
      m_cmd = 8'h21; m_isr = 8'h80; m_imr = 0; m_tsr = 0; m_rs = 0; m_rp = 0;
      m_bnd = 0; m_tpg = 0; m_rx = 0; m_tx = 0; m_dc = 0; m_cur = 0;
      m_tc = 0; m_ra = 0; m_rc = 0; m_started = 0; m_txgo = 0; m_spgo = 0;
      foreach (m_sta[i]) m_sta[i] = 0;
      foreach (m_mc[i])  m_mc[i]  = 0;
   endtask

   task automatic model_step();
      logic [7:0] d, ni;
      bit txok, s7, c7;
      txok = 0; s7 = 0; c7 = 0;
      m_txgo = 0; m_spgo = 0;
      ni = m_isr;
      d = wdata;
      if (wr_en && addr == 0) begin
         if (d[5:3] == 0) d[5] = 1'b1;
         txok = d[2] && (m_tc != 0);
         s7 = d[0];
         c7 = d[1] && !m_cmd[1];
         if (d[1]) m_started = 1;
         if (txok) begin m_tsr = 8'h01; m_txgo = 1; end
         if (d[5:3] == 3) begin m_ra = {m_bnd, 8'h00}; m_rc = 2; m_spgo = 1; end
         m_cmd = {d[7:3], txok, d[1:0]};
      end else if (wr_en) begin
         if (m_cmd[7:6] == 0) begin
            case (addr)
               1: m_rs = d;  2: m_rp = d;  3: m_bnd = d;  4: m_tpg = d;
               5: m_tc[7:0] = d;  6: m_tc[15:8] = d;
               7: ni[6:0] = ni[6:0] & ~d[6:0];
               8: m_ra[7:0] = d;  9: m_ra[15:8] = d;
               10: m_rc[7:0] = d; 11: m_rc[15:8] = d;
               12: m_rx = d; 13: m_tx = d; 14: m_dc = d; 15: m_imr = d;
               default: ;
            endcase
         end else if (m_cmd[7:6] == 1) begin
            if (addr <= 6)      m_sta[addr - 1] = d;
            else if (addr == 7) m_cur = d;
            else                m_mc[addr - 8] = d;
         end
      end
      ni[6:0] = ni[6:0] | evt_set;
      if (txok) ni[1] = 1'b1;
      if (c7) ni[7] = 1'b0;
      else if (s7) ni[7] = 1'b1;
      m_isr = ni;
   endtask

   function automatic logic [7:0] model_read(input logic [3:0] a);
      if (a == 0) return m_cmd;
      if (m_cmd[7:6] == 0) begin
         case (a)
            3: return m_bnd;  4: return m_tsr;  7: return m_isr;
            8: return m_ra[7:0];  9: return m_ra[15:8];
            10: return m_started ? 8'h50 : 8'hFF;
            11: return m_started ? 8'h43 : 8'hFF;
            default: return 8'h00;
         endcase
      end
      if (m_cmd[7:6] == 1) begin
         if (a <= 6) return m_sta[a - 1];
         if (a == 7) return m_cur;
         return m_mc[a - 8];
      end
      return 8'h00;
   endfunction

   function automatic string read_tag(input logic [3:0] a);
      if (a == 0 || m_cmd[7:6] != 0) return "R2";
      if (a == 10 || a == 11) return "R9";
      return "R10";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t addr=%0h)", tag, act, exp, $time, addr);
      end
   endtask

   always @(negedge clk) begin
      if (live && rst_n) begin
         logic [47:0] sta;
         logic [63:0] mc;
         foreach (m_sta[i]) sta[8*i +: 8] = m_sta[i];
         foreach (m_mc[i])  mc[8*i +: 8]  = m_mc[i];
         chk(read_tag(addr), rdata, model_read(addr));
         chk("R6 irq", irq, |(m_isr & m_imr));
         chk("R7 tx_go", tx_go, m_txgo);
         chk("R8 sendpkt_go", sendpkt_go, m_spgo);
         chk("R8 rdma_start", rdma_start, m_ra);
         chk("R8 rdma_count", rdma_count, m_rc);
         chk("R11 ring", {ring_start, ring_stop, boundary, tx_page}, {m_rs, m_rp, m_bnd, m_tpg});
         chk("R11 tx_count", tx_count, m_tc);
         chk("R11 cfg", {rx_cfg, tx_cfg, data_cfg}, {m_rx, m_tx, m_dc});
         chk("R2 page1 ports", {cur_page, station_addr}, {m_cur, sta});
         chk("R2 mcast", mcast_mask, mc);
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc(input bit w, input logic [3:0] a, input logic [7:0] d, input logic [6:0] e);
      wr_en = w; addr = a; wdata = d; evt_set = e;
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc(1, a, d, 0);
   endtask

   task automatic rd(input logic [3:0] a);
      cyc(0, a, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state seen at the ports
      chk("R1 cmd", rdata, 8'h21);
      chk("R1 irq", irq, 1'b0);
      chk("R1 strobes", {tx_go, sendpkt_go}, 2'b00);
      chk("R1 regs", {ring_start, tx_count, rdma_start, rdma_count, data_cfg}, '0);
      addr = 4'h7; #0.5;
      chk("R1 status", rdata, 8'h80);
      @(posedge clk); #1;
      live = 1'b1;

      rd(4'hA); rd(4'hB);                       // R9 before start
      wr(4'hF, 8'hFF);                          // R6 mask on, reset bit pending
      rd(4'h7);
      wr(4'h0, 8'h22);                          // R4 start rising clears bit 7
      rd(4'h7); rd(4'hA); rd(4'hB);             // R9 after start
      wr(4'h0, 8'h00);                          // R3 forced transfer code
      rd(4'h0); rd(4'hA);
      wr(4'h0, 8'h21);                          // R4 stop sets bit 7
      rd(4'h7);
      wr(4'h0, 8'h23);                          // R4 both: clear wins
      rd(4'h7);
      wr(4'h0, 8'h21); rd(4'h7);
      wr(4'h7, 8'hFF); rd(4'h7);                // R5 bit 7 untouched by clear
      cyc(0, 4'h7, 8'h00, 7'h15); rd(4'h7);     // R5 events
      wr(4'h7, 8'h05); rd(4'h7);                // R5 clear
      cyc(1, 4'h7, 8'h10, 7'h10); rd(4'h7);     // R5 event wins over clear
      wr(4'hF, 8'h00); rd(4'h7);                // R6 mask off
      wr(4'hF, 8'h20); rd(4'h0);

      // R11 page 0 writes, R10 unmapped reads
      for (int a = 1; a < 16; a++) if (a != 7) wr(4'(a), 8'(8'h30 + a * 7));
      for (int a = 0; a < 16; a++) rd(4'(a));

      // R2 page 1
      wr(4'h0, 8'h62);
      for (int a = 1; a < 16; a++) wr(4'(a), 8'(8'hA0 ^ (a * 13)));
      for (int a = 0; a < 16; a++) rd(4'(a));
      wr(4'h0, 8'hA2);                          // page 2: inert
      for (int a = 1; a < 16; a++) wr(4'(a), 8'h5A);
      for (int a = 0; a < 16; a++) rd(4'(a));
      wr(4'h0, 8'hE2); wr(4'h3, 8'h77); rd(4'h3);
      wr(4'h0, 8'h62); for (int a = 1; a < 16; a++) rd(4'(a));
      wr(4'h0, 8'h22); for (int a = 1; a < 16; a++) rd(4'(a));

      // R7 transmit
      wr(4'h5, 8'h00); wr(4'h6, 8'h00); wr(4'h7, 8'h7F);
      wr(4'h0, 8'h26); rd(4'h0); rd(4'h4); rd(4'h7);
      wr(4'h5, 8'h40);
      wr(4'h0, 8'h26); rd(4'h0); rd(4'h4); rd(4'h7);
      wr(4'hF, 8'h02); rd(4'h7);

      // R8 send packet
      wr(4'h3, 8'h4C);
      wr(4'h0, 8'h1A); rd(4'h8); rd(4'h9); rd(4'h0);
      wr(4'h0, 8'h5A); rd(4'h0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] a;
         logic [7:0] d;
         a = 4'($urandom_range(0, 15));
         d = 8'($urandom);
         if (a == 0 && $urandom_range(0, 3) != 0) d[0] = 1'b0;
         cyc($urandom_range(0, 2) == 0, a, d, ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0);
      end

      live = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule